// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is an I2C target that gives one host bus access to a small register file kept outside the block. A host first names the block with its 7-bit bus address. It then sends a command byte, and that byte becomes the register pointer. On a write, the single data byte that follows is stored at the pointer. On a read, the host issues a repeated START with the read bit set. The target then returns register contents most-significant bit first and advances the pointer by one after each byte. Two permission maps, one for writes and one for reads, say which registers may be stored to and read from. A command byte that names a protected or missing register is still accepted, but its data byte is dropped.

SCL and SDA are sampled through synchronizers in the system clock domain. The target pulls SDA low only while SCL is low. The register file is reached through a plain port: an address, a one-cycle write strobe with its data, and a combinational read-data input. Parameters set the bus address, the register count and the two maps. The defaults are bus address 0x2A and 16 registers. Register 1 is read-only, register 2 is write-only, and every address from 16 upward is missing.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is held, and until a START is seen after it, SDA is released (`sda_oe` low) and `rf_we` stays low.
- R2: A device byte whose upper seven bits equal the bus address (default 0x2A) is ACKed. Any other device byte is NACKed, and every later byte is ignored and NACKed until the next START.
- R3: After a device byte with R/W bit 0, the command byte is always ACKed and loaded into the 8-bit pointer. This holds even when it names a read-only or missing register. The pointer is kept across STOP.
- R4: The first data byte of a write is always ACKed. It is stored at the pointer with a one-cycle `rf_we` only if the write map allows that register; by default register 1 and addresses 16 and above are refused. A write does not move the pointer.
- R5: Any byte after the first data byte of a write is NACKed and is not stored.
- R6: A device byte with R/W bit 1 is ACKed only when the pointer names a readable register; otherwise it is NACKed and the target goes idle. By default register 2 and addresses 16 and above are not readable.
- R7: Read bytes come out MSB first from the register at the pointer, and the pointer advances by one after each byte sent.
- R8: Inside a read stream, a register the read map refuses returns 0x00.
- R9: After the byte from the top register (NREG-1) is sent, the pointer wraps to 0x00 and the target stops driving until the next START. Further clocked bytes therefore read 0xFF, and the next read starts at register 0.
- R10: A NACK from the host ends the read. The pointer keeps its increment, so the next read starts at the following register.
- R11: `sda_oe` changes only while SCL is low, about three system clocks after SCL falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rf_addr | output | $clog2(NREG) | Register-file address (low bits of the pointer) |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data for `rf_addr` (combinational) |

## Verification
Every result of this target is tied to an SCL edge seen through the synchronizer. ACK bits and read data bits reach `sda_oe` about three system clocks after the SCL fall that ends the previous bit. A write strobe comes the same number of clocks after the eighth SCL fall of the data byte. The bench master holds SCL low for sixteen clocks before each rising edge, and it reads SDA in the middle of the SCL high phase, well after the value has settled. A reference queue of expected writes is compared against `rf_we` on every falling clock edge. Acknowledge bits and read bytes are predicted from the behavioural register model and the expected pointer, independently of the design.

// File: rtl/i2c_regslave_pkg.sv
// Shared types for the I2C register target.
// Assumes: one-hot style is not needed; a compact binary state code is enough.
package i2c_regslave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_DEV,     // receiving device byte
        ST_CMD,     // receiving command (pointer) byte
        ST_WDATA,   // receiving first write data byte
        ST_WEXTRA,  // receiving surplus write bytes (NACKed)
        ST_ACK,     // target acknowledge clock
        ST_TX,      // sending a read byte
        ST_MACK     // host acknowledge clock after a read byte
    } st_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// SCL edges plus START and STOP conditions.
// Assumes: the bus idles high, STAGES >= 2, and SCL and SDA use the same depth
// so their relative order is preserved.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Shift chains and one-cycle-delayed copies of the synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    // Edge and bus-condition decode from the synchronized levels.
    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_hi    = sda_ff[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_hi;
        stop_det  = scl_s & scl_d & ~sda_d & sda_hi;
    end

endmodule

// File: rtl/i2c_access_map.sv
// Decodes read and write permission for an 8-bit register pointer.
// Assumes: addresses at or above NREG do not exist and are neither readable
// nor writable.
module i2c_access_map #(
    parameter int              NREG   = 16,
    parameter logic [NREG-1:0] RD_MAP = '1,
    parameter logic [NREG-1:0] WR_MAP = '1
) (
    input  logic [7:0] addr,
    output logic       rd_ok,
    output logic       wr_ok
);

    localparam int AW = $clog2(NREG);

    logic in_range;

    // Range check, then map lookup.
    always_comb begin
        in_range = ({1'b0, addr} < 9'(NREG));
        rd_ok    = in_range && RD_MAP[addr[AW-1:0]];
        wr_ok    = in_range && WR_MAP[addr[AW-1:0]];
    end

endmodule

// File: rtl/i2c_addr_ptr.sv
// Register pointer: loaded from the command byte, stepped after each read byte.
// Wraps from the top register to zero. Assumes load and step are never both set.
module i2c_addr_ptr #(
    parameter int NREG = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       step,
    output logic [7:0] ptr,
    output logic       at_top
);

    localparam logic [7:0] TOP = 8'(NREG - 1);

    assign at_top = (ptr == TOP);

    // Pointer update: load wins, step wraps at the top register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= 8'h00;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= at_top ? 8'h00 : ptr + 8'd1;
        end
    end

endmodule

// File: rtl/i2c_regslave.sv
// I2C target that fronts an external register file. It handles the device
// byte, the command (pointer) byte, one write data byte and streaming reads
// with auto-increment.
// Assumes: 7-bit addressing only, no clock stretching, and a register file
// that returns rf_rdata combinationally for rf_addr.
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter logic [6:0]      DEV_ADDR    = 7'h2A,
    parameter int              NREG        = 16,
    parameter logic [NREG-1:0] RD_MAP      = 16'hFFFB,
    parameter logic [NREG-1:0] WR_MAP      = 16'hFFFD,
    parameter int              SYNC_STAGES = 2,
    localparam int             AW          = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] rf_addr,
    output logic          rf_we,
    output logic [7:0]    rf_wdata,
    input  logic [7:0]    rf_rdata
);

    logic       sda_hi, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr;
    logic       at_top, rd_ok, wr_ok;
    logic       ptr_load, ptr_step;
    st_t        state, ack_next;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic       wrapped;
    logic       rx_state, rx_done, dev_match;
    logic [7:0] tx_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_hi    (sda_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_access_map #(.NREG(NREG), .RD_MAP(RD_MAP), .WR_MAP(WR_MAP)) u_map (
        .addr  (ptr),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    i2c_addr_ptr #(.NREG(NREG)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (shreg),
        .step     (ptr_step),
        .ptr      (ptr),
        .at_top   (at_top)
    );

    assign rf_addr = ptr[AW-1:0];

    // Byte-boundary decode and pointer control derived from the FSM.
    always_comb begin
        rx_state  = (state == ST_DEV) || (state == ST_CMD) ||
                    (state == ST_WDATA) || (state == ST_WEXTRA);
        rx_done   = rx_state && scl_fall && (cnt == 4'd8) && !start_det && !stop_det;
        dev_match = (shreg[7:1] == DEV_ADDR);
        ptr_load  = rx_done && (state == ST_CMD);
        ptr_step  = (state == ST_TX) && scl_fall && (cnt == 4'd8) && !start_det && !stop_det;
        tx_byte   = rd_ok ? rf_rdata : 8'h00;
    end

    // Main bit-level state machine: receive, acknowledge, transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            cnt      <= 4'd0;
            shreg    <= 8'h00;
            txsh     <= 8'h00;
            sda_oe   <= 1'b0;
            wrapped  <= 1'b0;
            rf_we    <= 1'b0;
            rf_wdata <= 8'h00;
        end else begin
            rf_we <= 1'b0;
            if (start_det) begin
                state  <= ST_DEV;
                cnt    <= 4'd0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_CMD, ST_WDATA, ST_WEXTRA: begin
                        if (scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_hi};
                            cnt   <= cnt + 4'd1;
                        end else if (rx_done) begin
                            state <= ST_ACK;
                            case (state)
                                ST_DEV: begin
                                    if (dev_match && !shreg[0]) begin
                                        sda_oe   <= 1'b1;
                                        ack_next <= ST_CMD;
                                    end else if (dev_match && rd_ok) begin
                                        sda_oe   <= 1'b1;
                                        ack_next <= ST_TX;
                                    end else begin
                                        sda_oe   <= 1'b0;
                                        ack_next <= ST_IDLE;
                                    end
                                end
                                ST_CMD: begin
                                    sda_oe   <= 1'b1;
                                    ack_next <= ST_WDATA;
                                end
                                ST_WDATA: begin
                                    sda_oe   <= 1'b1;
                                    ack_next <= ST_WEXTRA;
                                    rf_we    <= wr_ok;
                                    rf_wdata <= shreg;
                                end
                                default: begin
                                    sda_oe   <= 1'b0;
                                    ack_next <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt   <= 4'd0;
                            state <= ack_next;
                            if (ack_next == ST_TX) begin
                                txsh    <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                wrapped <= 1'b0;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                state   <= ST_MACK;
                                wrapped <= at_top;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                sda_oe <= ~txsh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (sda_hi || wrapped) begin
                                state <= ST_IDLE;
                            end
                        end else if (scl_fall) begin
                            cnt    <= 4'd0;
                            txsh   <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            state  <= ST_TX;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regslave_chk.sv
// Property checker for the I2C register target, bound to every instance.
// Assumes: observes ports plus the FSM state and the pointer controls.
module i2c_regslave_chk
    import i2c_regslave_pkg::*;
#(
    parameter int              NREG   = 16,
    parameter logic [NREG-1:0] WR_MAP = '1,
    localparam int             AW     = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          rf_we,
    input logic [AW-1:0] rf_addr,
    input st_t           state,
    input logic [7:0]    ptr,
    input logic          ptr_step
);

    localparam logic [7:0] TOP = 8'(NREG - 1);

    // R11
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R4
    we_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> WR_MAP[rf_addr]);

    // R5
    we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ($past(state) == ST_WDATA));

    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && ptr == TOP) |=> (ptr == 8'h00));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

bind i2c_regslave i2c_regslave_chk #(.NREG(NREG), .WR_MAP(WR_MAP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .rf_we    (rf_we),
    .rf_addr  (rf_addr),
    .state    (state),
    .ptr      (ptr),
    .ptr_step (ptr_step)
);

// File: tb/i2c_regslave_bench.sv
// Bench: bit-banged host, behavioural register file and an expected-write
// queue compared on every clock.
module i2c_regslave_bench;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [3:0] rf_addr;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;
    logic [7:0] ram [16];

    int checks = 0;
    int errors = 0;
    int r11_viol = 0;
    bit done = 0;
    logic [11:0] wq [$];
    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus  = sda_m & ~sda_oe;
    assign rf_rdata = ram[rf_addr];

    i2c_regslave u_i2c_regslave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .rf_addr  (rf_addr),
        .rf_we    (rf_we),
        .rf_wdata (rf_wdata),
        .rf_rdata (rf_rdata)
    );

    // Register file storage.
    always @(posedge clk) begin
        if (rf_we) ram[rf_addr] <= rf_wdata;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of write strobes and SDA timing against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we) begin
                checks++;
                if (wq.size() == 0) begin
                    errors++;
                    $display("FAIL R4/R5 unexpected write actual=%h:%h expected=none", rf_addr, rf_wdata);
                end else begin
                    logic [11:0] e;
                    e = wq.pop_front();
                    if ({rf_addr, rf_wdata} !== e) begin
                        errors++;
                        $display("FAIL R4 write actual=%h expected=%h", {rf_addr, rf_wdata}, e);
                    end
                end
            end
            if (scl_m && scl_prev && sda_oe != oe_prev) r11_viol++;
        end
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic wq_(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic v, output logic s);
        wq_(Q); sda_m = v;
        wq_(Q); scl_m = 1'b1;
        wq_(Q); s = sda_bus;
        wq_(Q); scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        if (!scl_m) begin
            wq_(Q); sda_m = 1'b1;
            wq_(Q); scl_m = 1'b1;
        end
        wq_(Q); sda_m = 1'b0;
        wq_(Q); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wq_(Q); sda_m = 1'b0;
        wq_(Q); scl_m = 1'b1;
        wq_(Q); sda_m = 1'b1;
        wq_(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            d[i] = s;
        end
        bit_cycle(mack, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic       a;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) ram[i] = 8'h40 + 8'(i);
        repeat (4) @(negedge clk);
        check("R1 sda_oe in reset", {7'd0, sda_oe}, 8'h00);
        check("R1 rf_we in reset", {7'd0, rf_we}, 8'h00);
        rst_n = 1'b1;
        wq_(20);
        check("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);

        // Valid write, then a surplus byte.
        i2c_start();
        send_byte(8'h54, a); check("R2 device ack", {7'd0, a}, 8'h00);
        send_byte(8'h03, a); check("R3 command ack", {7'd0, a}, 8'h00);
        wq.push_back({4'h3, 8'hA5});
        send_byte(8'hA5, a); check("R4 data ack", {7'd0, a}, 8'h00);
        send_byte(8'h77, a); check("R5 surplus nack", {7'd0, a}, 8'h01);
        i2c_stop();

        // Read back: pointer still 3.
        i2c_start();
        send_byte(8'h55, a); check("R6 read ack", {7'd0, a}, 8'h00);
        recv_byte(1'b1, d); check("R7 read reg3", d, 8'hA5);
        i2c_stop();

        // Next read continues at 4.
        i2c_start();
        send_byte(8'h55, a); check("R10 read ack", {7'd0, a}, 8'h00);
        recv_byte(1'b1, d); check("R10 read reg4", d, 8'h44);
        i2c_stop();

        // Wrong device address.
        i2c_start();
        send_byte(8'h56, a); check("R2 mismatch nack", {7'd0, a}, 8'h01);
        send_byte(8'h00, a); check("R2 ignored byte nack", {7'd0, a}, 8'h01);
        i2c_stop();

        // Write to read-only register 1.
        i2c_start();
        send_byte(8'h54, a); check("R2 device ack", {7'd0, a}, 8'h00);
        send_byte(8'h01, a); check("R3 read-only command ack", {7'd0, a}, 8'h00);
        send_byte(8'h99, a); check("R4 refused data ack", {7'd0, a}, 8'h00);
        i2c_stop();
        i2c_start();
        send_byte(8'h55, a); check("R3 read at loaded ptr ack", {7'd0, a}, 8'h00);
        recv_byte(1'b1, d); check("R4 reg1 unchanged", d, 8'h41);
        i2c_stop();

        // Pointer now 2 (write-only): read refused.
        i2c_start();
        send_byte(8'h55, a); check("R6 unreadable start nack", {7'd0, a}, 8'h01);
        i2c_stop();

        // Missing address.
        i2c_start();
        send_byte(8'h54, a);
        send_byte(8'h40, a); check("R3 missing command ack", {7'd0, a}, 8'h00);
        send_byte(8'h12, a); check("R4 missing data ack", {7'd0, a}, 8'h00);
        i2c_stop();
        i2c_start();
        send_byte(8'h55, a); check("R6 missing start nack", {7'd0, a}, 8'h01);
        i2c_stop();

        // Stream across the write-only register.
        i2c_start();
        send_byte(8'h54, a);
        send_byte(8'h01, a);
        i2c_start();
        send_byte(8'h55, a); check("R6 repeated start ack", {7'd0, a}, 8'h00);
        recv_byte(1'b0, d); check("R7 stream reg1", d, 8'h41);
        recv_byte(1'b0, d); check("R8 unreadable reads zero", d, 8'h00);
        recv_byte(1'b1, d); check("R7 stream reg3", d, 8'hA5);
        i2c_stop();

        // Roll over at the top register.
        i2c_start();
        send_byte(8'h54, a);
        send_byte(8'h0D, a);
        i2c_start();
        send_byte(8'h55, a);
        recv_byte(1'b0, d); check("R7 reg13", d, 8'h4D);
        recv_byte(1'b0, d); check("R7 reg14", d, 8'h4E);
        recv_byte(1'b0, d); check("R7 reg15", d, 8'h4F);
        recv_byte(1'b1, d); check("R9 released after top", d, 8'hFF);
        i2c_stop();
        i2c_start();
        send_byte(8'h55, a); check("R9 read after wrap ack", {7'd0, a}, 8'h00);
        recv_byte(1'b1, d); check("R9 reg0 after wrap", d, 8'h40);
        i2c_stop();

        wq_(10);
        check("R4 pending writes", 8'(wq.size()), 8'h00);
        check("R11 sda change while scl high", 8'(r11_viol), 8'h00);
        finish_run();
    end

endmodule